// File: doc/BRIEF.md
# Clocked Serial Master Receiver

This block receives bytes over a clock-synchronous serial link as the clock master. It generates the serial clock itself from the system clock, shifts eight data bits in per byte and hands each finished byte to software through a small register interface on a synchronous bus. The bus has address, write-enable, read-strobe and data signals, and read data is driven combinationally from the addressed register.

Software enables the receiver and then starts the stream by reading the data register once and discarding the value. After that, bytes follow one another with no further action as long as the receiver stays enabled, no stop has been requested and no overrun is pending. A receive-full flag tells software that a byte is waiting, and reading the data register clears it. If a second byte finishes before the first has been read, an overrun flag is raised, the older byte is kept and all further transfers are held off until software clears the flag. To end a stream, software sets the stop bit while the last byte is in flight. It then clears both the stop bit and the enable bit before it reads that final byte, because a read made while the receiver is still enabled starts a new byte.

Top module: `syncser_rx_master`

## Requirements
- R1: After reset the serial clock is high, busy is low, and the status, control and data registers all read 0.
- R2: The serial clock is high whenever busy is low. Inside a byte it is low for HALF system cycles and then high for HALF system cycles, once per bit.
- R3: A read of the data register (address 2) while the receiver is idle, enable is 1 and overrun is 0 starts a byte: in the next cycle busy is 1 and the serial clock is low.
- R4: Bits are captured MSB first, one on each rising edge of the serial clock. Busy falls in the same cycle that the eighth bit is captured.
- R5: When a byte completes with receive-full at 0, the byte goes to the data register and receive-full (status bit 0) becomes 1. A read of the data register clears receive-full.
- R6: When a byte completes while receive-full is 1 and there is no data-register read in that cycle, overrun (status bit 1) becomes 1, the data register keeps the older byte and the new byte is discarded.
- R7: While overrun is 1, no byte starts: neither a data-register read nor automatic continuation starts one.
- R8: A write to the status register (address 0) with bit 1 at 0 clears overrun. A write with bit 1 at 1 leaves overrun unchanged, and bit 0 of such a write has no effect.
- R9: After a byte completes, the next byte starts HALF cycles later when enable is 1, stop is 0 and overrun is 0, with no bus access needed.
- R10: With the stop bit (control bit 1) at 1, the byte in progress completes and no further byte begins.
- R11: With the enable bit (control bit 0) at 0, a read of the data register does not start a byte.
- R12: With enable and stop both cleared, reading the final byte returns it and does not start another byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 status, 1 control, 2 data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used for the side effects of a read) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| sclk_o | output | 1 | Generated serial clock, idles high |
| sdata_i | input | 1 | Serial data input |
| busy_o | output | 1 | High from the start of a byte until its last bit is captured |

## Verification
The stream is fed a rotating set of byte patterns (alternating bits, all zeros, all ones, a single top bit, a single bottom bit, a nibble pair), so a swapped bit order, a lost bit or an off-by-one capture shows up as a wrong byte value. Three read disciplines are applied: prompt reads that keep the stream flowing, reads withheld long enough to force an overrun, and a stop-then-disable sequence for the last byte. These separate the continuation rule, overrun retention and the restart-on-read hazard. Reads with the receiver disabled or with overrun pending show whether start gating depends on each condition.

// File: rtl/syncser_rx_pkg.sv
package syncser_rx_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CONTROL = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA    = 2'd2;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned CT_EN   = 0;
  localparam int unsigned CT_STOP = 1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_GAP   = 2'd2
  } phase_e;

  // Whether a byte may follow on: receiver enabled, no stop, no overrun.
  function automatic logic may_continue(input logic en, input logic stop, input logic ovr);
    return en && !stop && !ovr;
  endfunction

  // Overrun condition at completion of a byte.
  function automatic logic is_overrun(input logic full, input logic rd_hit);
    return full && !rd_hit;
  endfunction

endpackage

// File: rtl/syncser_rx_timing.sv
module syncser_rx_timing
  import syncser_rx_pkg::*;
#(
  parameter int unsigned HALF = 2,
  parameter int unsigned DW   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic run_ok,
  output logic sclk,
  output logic busy,
  output logic sample_pulse,
  output logic byte_done,
  output logic in_gap
);

  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned BW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q;
  logic          tick;

  assign tick         = (cnt_q == CNT_LAST);
  assign sample_pulse = (ph_q == PH_SHIFT) && tick && !sclk_q;
  assign byte_done    = sample_pulse && (bit_q == BIT_LAST);
  assign busy         = (ph_q == PH_SHIFT);
  assign in_gap       = (ph_q == PH_GAP);
  assign sclk         = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start_req) begin
            ph_q   <= PH_SHIFT;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
          end
        end
        PH_SHIFT: begin
          if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sample_pulse) begin
              bit_q <= bit_q + 1'b1;
            end
            if (byte_done) begin
              ph_q <= PH_GAP;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (tick) begin
            cnt_q <= '0;
            if (run_ok) begin
              ph_q   <= PH_SHIFT;
              sclk_q <= 1'b0;
              bit_q  <= '0;
            end else begin
              ph_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q   <= PH_IDLE;
          sclk_q <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/syncser_rx_shreg.sv
module syncser_rx_shreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_pulse,
  input  logic          sdata_i,
  output logic [DW-1:0] word_next
);

  logic [DW-1:0] shift_q;

  // MSB-first: earlier bits move toward the top as new ones arrive.
  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] cur, input logic b);
    return {cur[DW-2:0], b};
  endfunction

  assign word_next = push_bit(shift_q, sdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (sample_pulse) begin
      shift_q <= word_next;
    end
  end

endmodule

// File: rtl/syncser_rx_csr.sv
module syncser_rx_csr
  import syncser_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              byte_done,
  input  logic [DW-1:0]     word_in,
  output logic              start_req,
  output logic              run_ok,
  output logic              rd_data_hit,
  output logic              rx_en,
  output logic              stop_q,
  output logic              ovr_q,
  output logic              full_q,
  output logic [DW-1:0]     data_q
);

  logic wr_status;
  logic wr_control;
  logic ovr_set;
  logic ovr_clr;
  logic wdata_unused;

  assign wdata_unused = ^{bus_wdata[DW-1:2], bus_wdata[ST_FULL]};

  assign rd_data_hit = bus_re && (bus_addr == A_DATA);
  assign wr_status   = bus_we && (bus_addr == A_STATUS);
  assign wr_control  = bus_we && (bus_addr == A_CONTROL);
  assign ovr_set     = byte_done && is_overrun(full_q, rd_data_hit);
  assign ovr_clr     = wr_status && !bus_wdata[ST_OVR];

  assign start_req = rd_data_hit && rx_en && !ovr_q;
  assign run_ok    = may_continue(rx_en, stop_q, ovr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (byte_done && !ovr_set) begin
      full_q <= 1'b1;
      data_q <= word_in;
    end else if (rd_data_hit) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (ovr_set) begin
      ovr_q <= 1'b1;
    end else if (ovr_clr) begin
      ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      stop_q <= 1'b0;
    end else if (wr_control) begin
      rx_en  <= bus_wdata[CT_EN];
      stop_q <= bus_wdata[CT_STOP];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STATUS: begin
        bus_rdata[ST_FULL] = full_q;
        bus_rdata[ST_OVR]  = ovr_q;
      end
      A_CONTROL: begin
        bus_rdata[CT_EN]   = rx_en;
        bus_rdata[CT_STOP] = stop_q;
      end
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/syncser_rx_master.sv
module syncser_rx_master
  import syncser_rx_pkg::*;
#(
  parameter int unsigned HALF = 2,
  parameter int unsigned DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk_o,
  input  logic          sdata_i,
  output logic          busy_o
);

  logic          start_req;
  logic          run_ok;
  logic          rd_data_hit;
  logic          rx_en;
  logic          stop_q;
  logic          ovr_q;
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          sample_pulse;
  logic          byte_done;
  logic          in_gap;
  logic [DW-1:0] word_next;

  syncser_rx_timing #(.HALF(HALF), .DW(DW)) u_timing (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .run_ok       (run_ok),
    .sclk         (sclk_o),
    .busy         (busy_o),
    .sample_pulse (sample_pulse),
    .byte_done    (byte_done),
    .in_gap       (in_gap)
  );

  syncser_rx_shreg #(.DW(DW)) u_shreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_pulse (sample_pulse),
    .sdata_i      (sdata_i),
    .word_next    (word_next)
  );

  syncser_rx_csr #(.DW(DW)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .byte_done   (byte_done),
    .word_in     (word_next),
    .start_req   (start_req),
    .run_ok      (run_ok),
    .rd_data_hit (rd_data_hit),
    .rx_en       (rx_en),
    .stop_q      (stop_q),
    .ovr_q       (ovr_q),
    .full_q      (full_q),
    .data_q      (data_q)
  );

endmodule

// File: rtl/syncser_rx_checker.sv
module syncser_rx_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_o,
  input logic          busy_o,
  input logic          in_gap,
  input logic          byte_done,
  input logic          rd_data_hit,
  input logic          rx_en,
  input logic          stop_q,
  input logic          ovr_q,
  input logic          full_q,
  input logic [DW-1:0] data_q
);

  a_r2_sclk_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o);

  a_r3_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_hit && rx_en && !ovr_q && !busy_o && !in_gap) |=> (busy_o && !sclk_o));

  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !busy_o);

  a_r5_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !full_q) |=> full_q);

  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full_q && !rd_data_hit) |=> (ovr_q && $stable(data_q)));

  a_r7_ovr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !busy_o) |=> !busy_o);

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && stop_q) |=> !busy_o);

  a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !in_gap && !(rd_data_hit && rx_en)) |=> !busy_o);

endmodule

bind syncser_rx_master syncser_rx_checker #(.DW(DW)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .in_gap      (in_gap),
  .byte_done   (byte_done),
  .rd_data_hit (rd_data_hit),
  .rx_en       (rx_en),
  .stop_q      (stop_q),
  .ovr_q       (ovr_q),
  .full_q      (full_q),
  .data_q      (data_q)
);

// File: tb/test_syncser_rx_master.sv
module test_syncser_rx_master;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  wire  [7:0] bus_rdata;
  wire        sclk_o;
  wire        busy_o;
  logic       sdata_i = 1'b1;

  always #4 clk = ~clk;

  syncser_rx_master #(.HALF(HALF), .DW(8)) i_syncser_rx_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .sdata_i(sdata_i), .busy_o(busy_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // behavioural reference state
  bit       m_en, m_stop, m_ovr, m_full, m_run;
  logic [7:0] m_data, m_sh;
  int       m_pos, m_starts;
  bit       e_rd, e_done, e_full0;
  logic [7:0] tx_byte;

  function automatic logic [7:0] pat(input int n);
    case (n % 6)
      0: return 8'hA5;
      1: return 8'h00;
      2: return 8'hFF;
      3: return 8'h80;
      4: return 8'h01;
      default: return 8'h3C;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_stop = 0; m_ovr = 0; m_full = 0; m_run = 0;
      m_data = 8'h00; m_sh = 8'h00; m_pos = 0; m_starts = 0;
    end else begin
      e_rd = bus_re && (bus_addr == 2'd2);
      e_done = 0;
      e_full0 = m_full;
      if (m_run) begin
        m_pos++;
        if (m_pos <= 15*HALF && (m_pos % (2*HALF)) == HALF) m_sh = {m_sh[6:0], sdata_i};
        if (m_pos == 15*HALF) e_done = 1;
        if (m_pos == 16*HALF) begin
          if (m_en && !m_stop && !m_ovr) begin m_pos = 0; m_starts++; end
          else m_run = 0;
        end
      end else if (e_rd && m_en && !m_ovr) begin
        m_run = 1; m_pos = 0; m_starts++;
      end
      if (e_done && e_full0 && !e_rd) m_ovr = 1;
      else begin
        if (e_done) begin m_data = m_sh; m_full = 1; end
        else if (e_rd) m_full = 0;
        if (bus_we && bus_addr == 2'd0 && !bus_wdata[1]) m_ovr = 0;
      end
      if (bus_we && bus_addr == 2'd1) begin m_en = bus_wdata[0]; m_stop = bus_wdata[1]; end
    end
  end

  // serial data source, MSB first, one rotating pattern per byte
  always @(negedge clk) begin
    if (m_run && m_pos < 15*HALF) begin
      tx_byte = pat(m_starts - 1);
      sdata_i = tx_byte[7 - m_pos/(2*HALF)];
    end
  end

  function automatic logic [7:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {6'd0, m_ovr, m_full};
      2'd1: return {6'd0, m_stop, m_en};
      2'd2: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 sclk", {7'd0, sclk_o},
          {7'd0, !(m_run && m_pos < 15*HALF && (m_pos % (2*HALF)) < HALF)});
      chk("R4 busy", {7'd0, busy_o}, {7'd0, (m_run && m_pos < 15*HALF)});
      chk("R5 rdata", bus_rdata, m_rdata(bus_addr));
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic look(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_full();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      look(2'd0, s);
      if (s[0]) break;
    end
  endtask

  logic [7:0] v;

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 sclk", {7'd0, sclk_o}, 8'd1);
    chk("R1 busy", {7'd0, busy_o}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    look(2'd0, v); chk("R1 status", v, 8'h00);
    look(2'd1, v); chk("R1 control", v, 8'h00);
    look(2'd2, v); chk("R1 data", v, 8'h00);

    // R11: read with receiver disabled starts nothing
    rd(2'd2, v);
    repeat (20) @(negedge clk);
    #1 chk("R11 busy", {7'd0, busy_o}, 8'd0);

    // R3: enable, dummy read starts byte 0
    wr(2'd1, 8'h01);
    rd(2'd2, v);
    #1 chk("R3 busy", {7'd0, busy_o}, 8'd1);
    chk("R3 sclk", {7'd0, sclk_o}, 8'd0);

    // R9: automatic follow-on HALF cycles after completion
    wait_full();
    #1 chk("R9 busy gap", {7'd0, busy_o}, 8'd0);
    repeat (HALF - 1) @(negedge clk);
    #1 chk("R9 still gap", {7'd0, busy_o}, 8'd0);
    @(negedge clk);
    #1 chk("R9 next byte", {7'd0, busy_o}, 8'd1);
    rd(2'd2, v); chk("R4 byte0", v, pat(0));
    look(2'd0, v); chk("R5 full cleared", v, 8'h00);
    for (int k = 1; k < 3; k++) begin
      wait_full();
      rd(2'd2, v); chk("R4 byte", v, pat(k));
    end

    // R6: withhold reads until overrun
    repeat (100) @(negedge clk);
    look(2'd0, v); chk("R6 status", v, 8'h03);
    look(2'd2, v); chk("R6 kept", v, pat(3));
    #1 chk("R7 stopped", {7'd0, busy_o}, 8'd0);
    rd(2'd2, v); chk("R6 read", v, pat(3));
    repeat (40) @(negedge clk);
    #1 chk("R7 no start", {7'd0, busy_o}, 8'd0);
    wr(2'd0, 8'h03);
    look(2'd0, v); chk("R8 keep ovr", v, 8'h02);
    wr(2'd0, 8'h01);
    look(2'd0, v); chk("R8 cleared", v, 8'h00);

    // resume, then stop after the byte in flight
    rd(2'd2, v); chk("R7 resume read", v, pat(3));
    #1 chk("R7 resumed", {7'd0, busy_o}, 8'd1);
    wait_full();
    rd(2'd2, v); chk("R4 byte5", v, pat(5));
    wr(2'd1, 8'h03);
    repeat (100) @(negedge clk);
    #1 chk("R10 halted", {7'd0, busy_o}, 8'd0);
    look(2'd0, v); chk("R10 status", v, 8'h01);

    // R12: final read after disabling
    wr(2'd1, 8'h00);
    rd(2'd2, v); chk("R12 last", v, pat(6));
    repeat (40) @(negedge clk);
    #1 chk("R12 no restart", {7'd0, busy_o}, 8'd0);
    look(2'd0, v); chk("R12 status", v, 8'h00);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule